// File: doc/BRIEF.md
# Current-Limited PWM Generator

This block produces one high-side PWM output from a private period counter. Period and duty come in as plain inputs. They are captured into active registers only when a new cycle begins, so a mid-cycle write cannot distort the cycle that is running. A one-clock marker on `cycle_start_o` flags every cycle boundary.

A current-limit signal can be taken either from a comparator pin or from an external pin. When restart is enabled, a rising edge on the chosen source ends the low phase of the running cycle early and starts a fresh cycle. The block only accepts such an edge while the output is low. An edge that lands in the high phase is thrown away, so the on-time is always delivered in full. This suits converters that must keep inductor current above a floor: the off-time is cut short whenever the current sags.

Top module: `pwm_clim_top`

## Requirements
- R1: While `rst_ni` is low, `pwm_h_o` and `cycle_start_o` are both 0.
- R2: With no accepted current-limit event, the counter steps from 0 to P-1, where P is the active period. `cycle_start_o` pulses for one clock every P clocks, in the clock where the count is 0. A period of 0 or 1 restarts every clock.
- R3: Within a cycle, `pwm_h_o` is 1 while the count is below the active duty D and 0 from then on. The high clocks are therefore the first ones of the cycle.
- R4: Restart is enabled when `restart_en_i`=1. If the selected source goes high between two clock edges and the output is low when the event reaches the counter, the third rising edge after the change begins a new cycle. On that edge `cycle_start_o` goes to 1 and the count returns to 0.
- R5: An event that reaches the counter while `pwm_h_o` is 1 is discarded. It does not shorten the high time and it does not reset the period. It is also not deferred to the falling edge.
- R6: With `restart_en_i`=0, current-limit edges have no effect and every cycle runs its full period.
- R7: `clim_sel_i`=0 selects `clim_cmp_i` and `clim_sel_i`=1 selects `clim_ext_i`. The source that is not selected is ignored.
- R8: Only a rising edge counts as an event. A source held high yields one event in total.
- R9: `period_i` and `duty_i` take effect only at a cycle start. This includes a start caused by truncation. The running cycle keeps the values it was started with.
- R10: If D is equal to or greater than the cycle length, `pwm_h_o` is high for the whole cycle. If D=0, it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | W | Requested period in clocks |
| duty_i | input | W | Requested high time in clocks |
| restart_en_i | input | 1 | Allows current-limit edges to end the low phase |
| clim_sel_i | input | 1 | Current-limit source: 0 comparator, 1 external |
| clim_cmp_i | input | 1 | Comparator current-limit input (asynchronous) |
| clim_ext_i | input | 1 | External current-limit input (asynchronous) |
| pwm_h_o | output | 1 | High-side PWM output |
| cycle_start_o | output | 1 | One-clock marker at count 0 of each cycle |

## Verification
Suppose the counter or the shadow registers are corrupted. The fault then shows up as a wrong spacing between `cycle_start_o` pulses, or as the wrong number of high clocks. Either appears within one period of the corrupted cycle.

A fault in the synchronizer or in the on-phase gating shows up at the ports in one of two ways. A truncated cycle may end one clock off from the fixed three-edge latency. Or a cycle may end early when the event arrived during the high phase, which is visible in the same cycle that was hit.

Trials place an event at every count of a cycle. This separates the drop behaviour from a deferred restart, and shows the first cycle after a truncation already running on the new period.

// File: rtl/pwm_clim_pkg.sv
package pwm_clim_pkg;
  typedef enum logic {
    CLIM_SRC_CMP = 1'b0,
    CLIM_SRC_EXT = 1'b1
  } clim_src_e;

  localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/clim_event_det.sv
module clim_event_det
  import pwm_clim_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_sel_i,
  input  logic cmp_i,
  input  logic ext_i,
  output logic event_o
);
  localparam int unsigned TOP = SYNC_STAGES - 1;

  logic                   src;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  assign src = (clim_src_e'(src_sel_i) == CLIM_SRC_EXT) ? ext_i : cmp_i;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= src;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b0;
        else         sync_q[s] <= sync_q[s-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[TOP];
  end

  assign event_o = sync_q[TOP] & ~prev_q;

  // R8: each edge gives a single-clock event
  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |=> !event_o);
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] duty_i,
  output logic [W-1:0] act_period_o,
  output logic [W-1:0] act_duty_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_period_o <= '0;
      act_duty_o   <= '0;
    end else if (load_i) begin
      act_period_o <= period_i;
      act_duty_o   <= duty_i;
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] act_period_i,
  input  logic [W-1:0] act_duty_i,
  input  logic         restart_en_i,
  input  logic         event_i,
  output logic         load_o,
  output logic         pwm_h_o,
  output logic         cycle_start_o
);
  logic [W-1:0] cnt_q;
  logic [W:0]   cnt_inc;
  logic         first_q, cs_q;
  logic         last, on_phase, trunc;

  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign last     = cnt_inc >= {1'b0, act_period_i};
  assign on_phase = cnt_q < act_duty_i;
  // events in the on phase are dropped, never held
  assign trunc    = event_i & restart_en_i & ~on_phase;
  assign load_o   = first_q | last | trunc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
      cs_q    <= 1'b0;
    end else begin
      first_q <= 1'b0;
      cs_q    <= load_o;
      cnt_q   <= load_o ? '0 : cnt_inc[W-1:0];
    end
  end

  assign pwm_h_o       = on_phase;
  assign cycle_start_o = cs_q;

  a_r2_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_period_i != '0) |-> (cnt_q < act_period_i));

  a_r3_starts_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_start_o && act_duty_i != '0) |-> pwm_h_o);

  a_r4_truncates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i && restart_en_i && !pwm_h_o) |=> cycle_start_o);

  a_r5_on_time_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_h_o && !last && !first_q) |=> !cycle_start_o);

  a_r6_no_restart_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_en_i && !last && !first_q) |=> !cycle_start_o);
endmodule

// File: rtl/pwm_clim_top.sv
module pwm_clim_top
  import pwm_clim_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] duty_i,
  input  logic         restart_en_i,
  input  logic         clim_sel_i,
  input  logic         clim_cmp_i,
  input  logic         clim_ext_i,
  output logic         pwm_h_o,
  output logic         cycle_start_o
);
  logic         clim_event;
  logic         load;
  logic [W-1:0] act_period, act_duty;

  clim_event_det #(.SYNC_STAGES(SYNC_STAGES)) u_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_sel_i(clim_sel_i),
    .cmp_i    (clim_cmp_i),
    .ext_i    (clim_ext_i),
    .event_o  (clim_event)
  );

  pwm_shadow #(.W(W)) u_shadow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .period_i    (period_i),
    .duty_i      (duty_i),
    .act_period_o(act_period),
    .act_duty_o  (act_duty)
  );

  pwm_timebase #(.W(W)) u_tb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .act_period_i (act_period),
    .act_duty_i   (act_duty),
    .restart_en_i (restart_en_i),
    .event_i      (clim_event),
    .load_o       (load),
    .pwm_h_o      (pwm_h_o),
    .cycle_start_o(cycle_start_o)
  );

  // R9: active values only move at a cycle boundary
  a_r9_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cycle_start_o |-> ($stable(act_period) && $stable(act_duty)));

  always_comb begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (!pwm_h_o && !cycle_start_o);
    end
  end
endmodule

// File: tb/pwm_clim_top_tb_top.sv
module pwm_clim_top_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] period_i = '0;
  logic [W-1:0] duty_i = '0;
  logic         restart_en_i = 1'b0;
  logic         clim_sel_i = 1'b0;
  logic         clim_cmp_i = 1'b0;
  logic         clim_ext_i = 1'b0;
  logic         pwm_h_o, cycle_start_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  pwm_clim_top #(.W(W)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .period_i     (period_i),
    .duty_i       (duty_i),
    .restart_en_i (restart_en_i),
    .clim_sel_i   (clim_sel_i),
    .clim_cmp_i   (clim_cmp_i),
    .clim_ext_i   (clim_ext_i),
    .pwm_h_o      (pwm_h_o),
    .cycle_start_o(cycle_start_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_start();
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (cycle_start_o) return;
    end
    check(1'b0, "R2 start timeout", 0, 1);
  endtask

  // Entered on the negedge where cycle_start_o is 1 (index 0).
  // Returns on the negedge of the next start.
  task automatic run_cycle(input int inj, input bit hold, input bit on_ext,
                           input int chg_at, input int chg_p, input int chg_d,
                           output int len, output int hi, output bit shape_ok);
    int  i = 0;
    bit  seen_low = 1'b0;
    bit  drive;
    hi = 0;
    shape_ok = 1'b1;
    forever begin
      if (pwm_h_o) begin
        hi++;
        if (seen_low) shape_ok = 1'b0;
      end else seen_low = 1'b1;
      drive = hold ? (i >= inj) : (i == inj);
      clim_ext_i = on_ext ? drive : 1'b0;
      clim_cmp_i = on_ext ? 1'b0 : drive;
      if (i == chg_at) begin
        period_i = W'(chg_p);
        duty_i   = W'(chg_d);
      end
      @(negedge clk);
      i++;
      if (cycle_start_o || i > 300) break;
    end
    len = i;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int len, hi;
    bit shp;

    // R1: reset state
    period_i = W'(10);
    duty_i   = W'(4);
    repeat (3) begin
      @(negedge clk);
      check(!pwm_h_o, "R1 pwm_h in reset", int'(pwm_h_o), 0);
      check(!cycle_start_o, "R1 cycle_start in reset", int'(cycle_start_o), 0);
    end
    rst_ni = 1'b1;

    // R2 R3 R10: sweep period and duty, no events
    for (int p = 2; p <= 6; p++) begin
      for (int d = 0; d <= p + 1; d++) begin
        period_i = W'(p);
        duty_i   = W'(d);
        wait_start();
        run_cycle(-1, 1'b0, 1'b0, -1, 0, 0, len, hi, shp);
        check(len == p, "R2 period length", len, p);
        check(hi == ((d < p) ? d : p), "R10 high count", hi, (d < p) ? d : p);
        check(shp, "R3 high first", int'(shp), 1);
      end
    end

    // R4 R5: event at every index, P=10 D=4
    period_i = W'(10);
    duty_i   = W'(4);
    restart_en_i = 1'b1;
    clim_sel_i   = 1'b0;
    wait_start();
    wait_start();
    for (int j = 0; j <= 6; j++) begin
      int exp_len;
      exp_len = (j + 2 >= 4) ? j + 3 : 10;
      run_cycle(j, 1'b0, 1'b0, -1, 0, 0, len, hi, shp);
      check(len == exp_len, (j + 2 >= 4) ? "R4 truncated length" : "R5 on-time event dropped",
            len, exp_len);
      check(hi == 4, "R5 full on-time", hi, 4);
    end

    // R7: source select
    run_cycle(5, 1'b0, 1'b1, -1, 0, 0, len, hi, shp);
    check(len == 10, "R7 ext ignored when cmp selected", len, 10);
    clim_sel_i = 1'b1;
    run_cycle(5, 1'b0, 1'b1, -1, 0, 0, len, hi, shp);
    check(len == 8, "R7 ext selected truncates", len, 8);
    run_cycle(5, 1'b0, 1'b0, -1, 0, 0, len, hi, shp);
    check(len == 10, "R7 cmp ignored when ext selected", len, 10);

    // R6: restart disabled
    restart_en_i = 1'b0;
    run_cycle(5, 1'b0, 1'b1, -1, 0, 0, len, hi, shp);
    check(len == 10, "R6 disabled no truncation", len, 10);
    restart_en_i = 1'b1;

    // R8: held source gives one event
    run_cycle(5, 1'b1, 1'b1, -1, 0, 0, len, hi, shp);
    check(len == 8, "R8 first edge truncates", len, 8);
    run_cycle(0, 1'b1, 1'b1, -1, 0, 0, len, hi, shp);
    check(len == 10, "R8 held level no second event", len, 10);
    run_cycle(-1, 1'b0, 1'b1, -1, 0, 0, len, hi, shp);
    check(len == 10, "R8 falling edge no event", len, 10);

    // R9: shadow load at natural and truncated starts
    run_cycle(-1, 1'b0, 1'b1, 1, 6, 2, len, hi, shp);
    check(len == 10, "R9 running period kept", len, 10);
    check(hi == 4, "R9 running duty kept", hi, 4);
    run_cycle(1, 1'b0, 1'b1, 1, 10, 4, len, hi, shp);
    check(len == 6 - 2, "R9 new values applied, truncated", len, 4);
    check(hi == 2, "R9 new duty applied", hi, 2);
    run_cycle(-1, 1'b0, 1'b1, -1, 0, 0, len, hi, shp);
    check(len == 10, "R9 load on truncated start", len, 10);
    check(hi == 4, "R9 duty load on truncated start", hi, 4);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule